// File: doc/BRIEF.md
# Set-Associative Cache Read Lookup

This unit is the read path of a small on-chip cache. It holds `2^SET_W` sets, each with `WAYS` lines, and each line holds one block of `2^OFF_W` bytes. A byte address is split into a tag in the high bits, a set index in the middle bits and a byte offset in the low bits. The set index selects one set. The tags of all ways in that set are compared in parallel, and the unit answers either with the addressed byte (a hit) or by fetching the whole block from the next memory level (a miss). `WAYS = 1` gives a direct-mapped cache.

One request is in flight at a time. A controller FSM has four states:

- `ST_IDLE` accepts a request (IDLE→LOOKUP on `req_valid`).
- `ST_LOOKUP` answers a hit at once (LOOKUP→IDLE) or starts a refill (LOOKUP→REFILL).
- `ST_REFILL` holds the block request until the next level acknowledges it (REFILL→RESPOND on `fill_ack`).
- `ST_RESPOND` returns the byte from the block that was just written (RESPOND→IDLE).

Victim choice takes the lowest-numbered invalid way first. When the set is full, it takes the least-recently-used way.

Top module: `sa_cache_lookup`

## Requirements
- R1: Address bits `[OFF_W-1:0]` are the byte offset, bits `[OFF_W+SET_W-1:OFF_W]` the set index, and the remaining upper bits the tag. Consecutive blocks therefore land in different sets.
- R2: After reset no line is valid: `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0, `busy`=0, and the first read of any address misses.
- R3: A read hits only when some way of the selected set is valid and holds the address tag. At most one way matches.
- R4: On a hit, `rsp_valid`=1 and `rsp_hit`=1 in the cycle after acceptance. `rsp_data` is the byte at the offset, and `mem_req_valid` stays 0.
- R5: On a miss, `mem_req_valid` and `busy` rise two cycles after acceptance, with `mem_req_addr` = address >> `OFF_W`. Both are held, with the address stable and `req_ready`=0, until `fill_ack`.
- R6: In the cycle after `fill_ack`, `rsp_valid`=1 and `rsp_hit`=0, with the byte taken from `fill_data`. Byte k of a block is `fill_data[8k+7:8k]`. The filled line is then valid and hits on later reads.
- R7: A fill goes to the lowest-numbered invalid way. When all ways are valid, it goes to the least-recently-used way.
- R8: Recency is updated by every hit and every fill.
- R9: Direct-mapped with 4-bit addresses, 2-byte blocks and 4 sets: the read trace 0, 1, 13, 8, 0 gives miss, hit, miss, miss, miss.
- R10: Two ways, 4-byte blocks and 8 sets is a supported configuration, covered by R1–R8 at the default parameters.
- R11: `req_valid` while `req_ready`=0 is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Byte address |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Response came from a hit |
| rsp_data | output | 8 | Addressed byte |
| mem_req_valid | output | 1 | Block request to the next level |
| mem_req_addr | output | ADDR_W-OFF_W | Block address |
| fill_ack | input | 1 | Next level returns the block |
| fill_data | input | 8<<OFF_W | Block contents |
| busy | output | 1 | Miss outstanding |

## Verification
The assertions watch the following on every cycle:
- at most one way matches;
- a hit answers exactly one cycle after acceptance;
- a block request starts two cycles after acceptance and stays stable until acknowledged;
- a miss response only follows an acknowledged fill.

Only the bench's scenarios can show that the right line was evicted. They do this through the hit or miss pattern of later reads checked against a timestamp model of recency, together with the fixed direct-mapped trace, the offset byte selection and the ignored request during a refill.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REFILL,
        ST_RESPOND
    } cache_state_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
    parameter int ADDR_W = 12,
    parameter int SET_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [ADDR_W-SET_W-OFF_W-1:0]  tag_o,
    output logic [SET_W-1:0]               set_o,
    output logic [OFF_W-1:0]               off_o
);
    // R1: offset low, set index in the middle, tag on top
    assign off_o = addr_i[OFF_W-1:0];
    assign set_o = addr_i[OFF_W+SET_W-1:OFF_W];
    assign tag_o = addr_i[ADDR_W-1:OFF_W+SET_W];
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 7,
    parameter int AGE_W = 1,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]       line_valid,
    input  logic [WAYS*TAG_W-1:0] line_tags,
    input  logic [WAYS*AGE_W-1:0] line_ages,
    input  logic [TAG_W-1:0]      tag_i,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic [WAY_W-1:0]      victim_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = line_valid[w] && (line_tags[w*TAG_W +: TAG_W] == tag_i);
    end

    assign hit = |hit_vec;

    always_comb begin
        logic found;
        hit_way    = '0;
        victim_way = '0;
        found      = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !line_valid[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (line_ages[w*AGE_W +: AGE_W] == AGE_W'(WAYS-1)) victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cache_lru_ages.sv
module cache_lru_ages #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 1,
    parameter int WAY_W = 1
) (
    input  logic [WAYS*AGE_W-1:0] ages_i,
    input  logic [WAY_W-1:0]      touch_way,
    output logic [WAYS*AGE_W-1:0] ages_o
);
    logic [AGE_W-1:0] touch_age;
    assign touch_age = ages_i[int'(touch_way)*AGE_W +: AGE_W];

    // touched way becomes youngest; ways younger than it age by one
    for (genvar w = 0; w < WAYS; w++) begin : g_age
        logic [AGE_W-1:0] cur;
        assign cur = ages_i[w*AGE_W +: AGE_W];
        assign ages_o[w*AGE_W +: AGE_W] =
            (int'(touch_way) == w) ? '0 :
            (cur < touch_age)      ? cur + AGE_W'(1) : cur;
    end
endmodule

// File: rtl/sa_cache_lookup.sv
module sa_cache_lookup
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SET_W  = 3,
    parameter int OFF_W  = 2,
    parameter int WAYS   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      req_ready,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [7:0]                rsp_data,
    output logic                      mem_req_valid,
    output logic [ADDR_W-OFF_W-1:0]   mem_req_addr,
    input  logic                      fill_ack,
    input  logic [(8<<OFF_W)-1:0]     fill_data,
    output logic                      busy
);
    localparam int TAG_W    = ADDR_W - SET_W - OFF_W;
    localparam int SETS     = 1 << SET_W;
    localparam int BLK_BITS = 8 << OFF_W;
    localparam int AGE_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

    cache_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [WAY_W-1:0]  fill_way_q;

    logic [WAYS-1:0]       valid_q [SETS];
    logic [WAYS*TAG_W-1:0] tags_q  [SETS];
    logic [WAYS*AGE_W-1:0] ages_q  [SETS];
    logic [BLK_BITS-1:0]   data_q  [SETS][WAYS];

    logic [TAG_W-1:0]      cur_tag;
    logic [SET_W-1:0]      cur_set;
    logic [OFF_W-1:0]      cur_off;
    logic [WAYS-1:0]       hit_vec;
    logic                  hit;
    logic [WAY_W-1:0]      hit_way, victim_way, touch_way;
    logic [WAYS*AGE_W-1:0] ages_next;
    logic                  line_write, lru_write;
    logic [BLK_BITS-1:0]   rd_line;

    cache_addr_split #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_split (
        .addr_i(addr_q), .tag_o(cur_tag), .set_o(cur_set), .off_o(cur_off)
    );

    cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_match (
        .line_valid(valid_q[cur_set]), .line_tags(tags_q[cur_set]),
        .line_ages(ages_q[cur_set]), .tag_i(cur_tag),
        .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
    );

    assign touch_way = (state_q == ST_REFILL) ? fill_way_q : hit_way;

    cache_lru_ages #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_lru (
        .ages_i(ages_q[cur_set]), .touch_way(touch_way), .ages_o(ages_next)
    );

    assign line_write = (state_q == ST_REFILL) && fill_ack;
    assign lru_write  = line_write || ((state_q == ST_LOOKUP) && hit);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = hit ? ST_IDLE : ST_REFILL;
            ST_REFILL:  if (fill_ack) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            fill_way_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state_q == ST_LOOKUP && !hit) fill_way_q <= victim_way;
        end
    end

    // valid bits and recency ages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) ages_q[s][w*AGE_W +: AGE_W] <= AGE_W'(w);
            end
        end else begin
            if (line_write) valid_q[cur_set][fill_way_q] <= 1'b1;
            if (lru_write)  ages_q[cur_set] <= ages_next;
        end
    end

    // tag and data storage
    always_ff @(posedge clk) begin
        if (line_write) begin
            tags_q[cur_set][int'(fill_way_q)*TAG_W +: TAG_W] <= cur_tag;
            data_q[cur_set][fill_way_q] <= fill_data;
        end
    end

    // output logic
    always_comb begin
        rd_line       = (state_q == ST_RESPOND) ? data_q[cur_set][fill_way_q]
                                                : data_q[cur_set][hit_way];
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = ((state_q == ST_LOOKUP) && hit) || (state_q == ST_RESPOND);
        rsp_hit       = (state_q == ST_LOOKUP) && hit;
        rsp_data      = rsp_valid ? rd_line[{cur_off, 3'b000} +: 8] : 8'h00;
        mem_req_valid = (state_q == ST_REFILL);
        mem_req_addr  = addr_q[ADDR_W-1:OFF_W];
        busy          = (state_q == ST_REFILL);
    end

    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> $onehot0(hit_vec)); // R3
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready)); // R4
    AST_MISS_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(req_valid && req_ready, 2)); // R5
    AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !fill_ack) |=> (mem_req_valid && busy && $stable(mem_req_addr))); // R5
    AST_MISS_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> $past(mem_req_valid && fill_ack)); // R6
endmodule

// File: tb/sa_cache_lookup_test.sv
`timescale 1ns/1ps

module cache_harness #(
    parameter int ADDR_W = 12,
    parameter int SET_W  = 3,
    parameter int OFF_W  = 2,
    parameter int WAYS   = 2,
    parameter int MODE   = 1
) (
    input  logic clk,
    input  logic rst_n,
    output int   checks,
    output int   fails,
    output logic done
);
    localparam int SETS = 1 << SET_W;
    localparam int BLKB = 1 << OFF_W;

    logic                    req_valid, req_ready, rsp_valid, rsp_hit;
    logic [ADDR_W-1:0]       req_addr;
    logic [7:0]              rsp_data;
    logic                    mem_req_valid, fill_ack, busy;
    logic [ADDR_W-OFF_W-1:0] mem_req_addr;
    logic [(8<<OFF_W)-1:0]   fill_data;

    sa_cache_lookup #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .WAYS(WAYS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .fill_ack(fill_ack), .fill_data(fill_data), .busy(busy)
    );

    // behavioural model: valid, tag, last-use timestamp per line
    bit mv [SETS][WAYS];
    int mt [SETS][WAYS];
    int ms [SETS][WAYS];
    int now;

    function automatic int mem_byte(int a);
        return (a * 37 + 11) % 256;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(int a, int lat, int exp_hit, string req, bit poke);
        int s, t, way, mhit, obs, vic, oldest;
        s = (a >> OFF_W) % SETS;
        t = a >> (OFF_W + SET_W);
        mhit = 0; way = 0;
        for (int w = 0; w < WAYS; w++) if (mv[s][w] && mt[s][w] == t) begin mhit = 1; way = w; end
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = ADDR_W'(a);
        @(negedge clk);
        req_valid = 1'b0;
        now++;
        obs = int'(rsp_valid && rsp_hit);
        chk(obs == mhit, "R3 hit vs model", obs, mhit);
        if (exp_hit >= 0) chk(obs == exp_hit, req, obs, exp_hit);
        if (mhit == 1) begin
            chk(rsp_data == 8'(mem_byte(a)), "R4 hit byte", int'(rsp_data), mem_byte(a));
            chk(!mem_req_valid, "R4 no block request on hit", int'(mem_req_valid), 0);
            ms[s][way] = now;
        end else begin
            chk(!rsp_valid, "R2 no response in miss lookup", int'(rsp_valid), 0);
            @(negedge clk);
            chk(mem_req_valid && busy && !req_ready, "R5 refill flags", int'(mem_req_valid), 1);
            chk(int'(mem_req_addr) == (a >> OFF_W), "R1 block address", int'(mem_req_addr), a >> OFF_W);
            for (int i = 0; i < lat; i++) begin
                if (poke) begin req_valid = 1'b1; req_addr = ADDR_W'(a ^ 1); end
                @(negedge clk);
                chk(mem_req_valid && int'(mem_req_addr) == (a >> OFF_W), "R5 request held",
                    int'(mem_req_addr), a >> OFF_W);
            end
            req_valid = 1'b0;
            for (int k = 0; k < BLKB; k++)
                fill_data[8*k +: 8] = 8'(mem_byte(((a >> OFF_W) << OFF_W) + k));
            fill_ack = 1'b1;
            @(negedge clk);
            fill_ack = 1'b0;
            chk(rsp_valid && !rsp_hit, "R6 miss response", int'(rsp_hit), 0);
            chk(rsp_data == 8'(mem_byte(a)), "R6 filled byte", int'(rsp_data), mem_byte(a));
            vic = -1; oldest = 0;
            for (int w = 0; w < WAYS; w++) if (vic < 0 && !mv[s][w]) vic = w;
            if (vic < 0) begin
                vic = 0; oldest = ms[s][0];
                for (int w = 1; w < WAYS; w++) if (ms[s][w] < oldest) begin vic = w; oldest = ms[s][w]; end
            end
            mv[s][vic] = 1'b1; mt[s][vic] = t; ms[s][vic] = now;
            if (poke) begin
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    chk(!rsp_valid && req_ready, "R11 ignored request", int'(rsp_valid), 0);
                end
            end
        end
    endtask

    localparam int A = (5 << 5) | (3 << 2);
    localparam int B = (9 << 5) | (3 << 2);
    localparam int C = (17 << 5) | (3 << 2);

    initial begin
        checks = 0; fails = 0; done = 1'b0; now = 0;
        req_valid = 1'b0; req_addr = '0; fill_ack = 1'b0; fill_data = '0;
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin
            mv[s][w] = 1'b0; mt[s][w] = 0; ms[s][w] = 0;
        end
        wait (rst_n == 1'b1);
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid && !busy, "R2 reset outputs", int'(busy), 0);
        if (MODE == 0) begin
            rd(0,  2, 0, "R9 trace 0 miss", 1'b0);
            rd(1,  0, 1, "R9 trace 1 hit", 1'b0);
            rd(13, 1, 0, "R9 trace 13 miss", 1'b0);
            rd(8,  0, 0, "R9 trace 8 miss", 1'b0);
            rd(0,  3, 0, "R9 trace 0 conflict miss", 1'b0);
        end else begin
            rd(A,     3, 0, "R2 cold miss", 1'b0);
            rd(A + 1, 0, 1, "R4 R10 offset hit", 1'b0);
            rd(B,     1, 0, "R7 invalid way filled", 1'b0);
            rd(A + 2, 0, 1, "R8 hit refreshes", 1'b0);
            rd(B + 3, 0, 1, "R7 both ways resident", 1'b0);
            rd(A + 3, 0, 1, "R8 hit refreshes", 1'b0);
            rd(C,     2, 0, "R7 LRU victim", 1'b1);
            rd(A,     0, 1, "R8 MRU line kept", 1'b0);
            rd(B,     0, 0, "R8 LRU line evicted", 1'b0);
            rd(C + 1, 0, 0, "R8 fill made C oldest", 1'b0);
            rd(32'h20, 0, 0, "R1 set0 miss", 1'b0);
            rd(32'h24, 0, 0, "R1 next block other set", 1'b0);
            rd(32'h21, 0, 1, "R1 set0 still resident", 1'b0);
            rd(32'h27, 0, 1, "R1 set1 still resident", 1'b0);
        end
        done = 1'b1;
    end
endmodule

module sa_cache_lookup_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c0, f0, c1, f1;
    logic d0, d1;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    cache_harness #(.ADDR_W(4), .SET_W(2), .OFF_W(1), .WAYS(1), .MODE(0)) h_dm (
        .clk(clk), .rst_n(rst_n), .checks(c0), .fails(f0), .done(d0)
    );
    cache_harness #(.ADDR_W(12), .SET_W(3), .OFF_W(2), .WAYS(2), .MODE(1)) h_sa (
        .clk(clk), .rst_n(rst_n), .checks(c1), .fails(f1), .done(d1)
    );

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        wait (d0 && d1);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", c0 + c1, f0 + f1);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", c0 + c1 + 1, f0 + f1 + 1);
            $finish;
        end
    end
endmodule